// File: doc/BRIEF.md
# Dual Divider Bank Output Crosspoint

This block produces six gated clock outputs from two post-divider banks. Each bank clocks itself from either the VCO clock or the reference clock, as a per-bank source bit chooses. It divides that clock by a programmable N and also produces two fixed-ratio taps. Bank 1 offers /2 and /3 taps and bank 2 offers /2 and /4 taps. The taps come from the same counter as the /N output, so their rising edges line up with it when N suits the ratio.

Each of the six outputs has a 3-bit selector that picks the reference, one of the six divider outputs, or a reserved code that holds the output low. Each output also has its own enable. An enable change takes effect only on a falling edge of the selected source, so an output never emits a shortened pulse. A change of N or of the source bit restarts the bank's counter and all its taps together.

Top module: `dual_bank_clk_xbar`

## Requirements
- R1: Bit 7 of a bank configuration byte picks that bank's input clock: 0 selects the VCO clock, 1 selects the reference clock.
- R2: The /N output of a bank has a period of N input periods and a high time of N/2 input periods, including odd N, where the extra half period comes from the falling edge.
- R3: An N field (bits 6..0 of the bank configuration) below 4 divides as if it were 4.
- R4: The bank 1 /2 and /3 taps have periods of 2 and 3 input periods and high times of 1 and 1.5 input periods. The /2 tap rises together with /N when N is a multiple of 4, and the /3 tap rises together with /N when N is 6.
- R5: The bank 2 /2 and /4 taps have periods of 2 and 4 input periods and high times of 1 and 2 input periods. The /2 tap rises with /N when N is a multiple of 4, and the /4 tap rises with /N when N is a multiple of 8.
- R6: Selector codes: 0 reference, 1 bank 1 /N, 2 bank 1 /2, 3 bank 1 /3, 4 bank 2 /N, 5 bank 2 /2, 6 bank 2 /4. The selector for output 1 sits in route_sel[17:15], output 2 in [14:12], and so on down to output 6 in [2:0].
- R7: An output whose selector holds code 7 stays low.
- R8: out_en bit k enables clk_out bit k (output k+1) when 1; a disabled output stays low.
- R9: An enable change takes effect at the next falling edge of the selected source, so a pulse in progress is finished and no partial pulse starts.
- R10: Changing N or the source bit of a bank restarts its counter, and afterwards its taps are again aligned with its /N output.
- R11: While the synchronous active-low reset is asserted, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | VCO clock |
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bank1_cfg | input | 8 | Bank 1: bit 7 source, bits 6..0 N |
| bank2_cfg | input | 8 | Bank 2: bit 7 source, bits 6..0 N |
| route_sel | input | 18 | Six 3-bit source selectors, output 1 in the top bits |
| out_en | input | 6 | Per-output enable, bit 0 = output 1 |
| clk_out | output | 6 | Gated output clocks, bit 0 = output 1 |

## Verification
A wrong counter state in a bank shows at the ports within one /N period: the period or the high time of the affected outputs changes, or a tap's rising edge no longer coincides with /N. The bench measures edge timestamps after each configuration has settled for several periods, so a restart that fails to happen shows up as misaligned edges after the change. A wrong enable register shows within one source period, as a pulse that is truncated or that starts too early around an enable toggle.

// File: rtl/dbx_pkg.sv
// Shared constants and the source-code encoding of the output crosspoint.
// Assumes three selector bits and eight source slots; slot 7 is reserved.
package dbx_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_SRC = 1 << SEL_W;

    typedef enum logic [SEL_W-1:0] {
        SRC_REF     = 3'd0,
        SRC_B1_N    = 3'd1,
        SRC_B1_HALF = 3'd2,
        SRC_B1_FIX  = 3'd3,
        SRC_B2_N    = 3'd4,
        SRC_B2_HALF = 3'd5,
        SRC_B2_FIX  = 3'd6,
        SRC_RSVD    = 3'd7
    } src_code_e;
endpackage

// File: rtl/dbx_div_bank.sv
// One post-divider bank. It divides its bank clock by N (clamped to N_MIN or
// more) and derives a /2 tap and a fixed tap (/3 or /4, chosen by FIX_RATIO)
// from the same counter, so tap rising edges land on /N rising edges.
// It assumes bclk is already the selected source; a change in the source bit
// or in N restarts the counter. Odd ratios use a falling-edge flop so the
// high phase lasts half a period longer.
module dbx_div_bank #(
    parameter int N_W       = 7,
    parameter int N_MIN     = 4,
    parameter int FIX_RATIO = 3
) (
    input  logic           bclk,
    input  logic           rst_n,
    input  logic           src_bit,
    input  logic [N_W-1:0] n_cfg,
    output logic           div_n_o,
    output logic           half_o,
    output logic           fix_o
);
    localparam int CFG_W = N_W + 1;

    logic [CFG_W-1:0] cfg_q;
    logic [N_W-1:0]   n_eff, n_prev, half_n, cnt_q, nxt;
    logic             chg, odd_n, pos_q, neg_q, t2_q;

    // Effective ratio for the current and previous configuration.
    assign n_eff  = (n_cfg < N_W'(N_MIN)) ? N_W'(N_MIN) : n_cfg;
    assign n_prev = (cfg_q[N_W-1:0] < N_W'(N_MIN)) ? N_W'(N_MIN) : cfg_q[N_W-1:0];
    assign half_n = n_eff >> 1;
    assign odd_n  = n_eff[0];
    assign chg    = ({src_bit, n_cfg} != cfg_q);

    // Next count: wrap at N-1 or restart on a configuration change.
    always_comb begin
        if (chg || (cnt_q >= n_eff - 1'b1)) nxt = '0;
        else                                 nxt = cnt_q + 1'b1;
    end

    // Counter, /N high phase and /2 tap, all on the rising edge.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            cfg_q <= {src_bit, n_cfg};
            cnt_q <= n_eff - 1'b1;
            pos_q <= 1'b0;
            t2_q  <= 1'b0;
        end else begin
            cfg_q <= {src_bit, n_cfg};
            cnt_q <= nxt;
            pos_q <= (nxt < half_n);
            t2_q  <= ~nxt[0];
        end
    end

    // Half-period extension of the /N high phase for odd N.
    always_ff @(negedge bclk) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= pos_q;
    end

    assign div_n_o = pos_q | (odd_n & neg_q);
    assign half_o  = t2_q;

    generate
        if (FIX_RATIO == 4) begin : g_div4
            logic t4_q;
            // Quarter-rate tap taken from counter bit 1.
            always_ff @(posedge bclk) begin
                if (!rst_n) t4_q <= 1'b0;
                else        t4_q <= ~nxt[1];
            end
            assign fix_o = t4_q;
        end else begin : g_div3
            logic [1:0] c3_q, c3_nxt;
            logic       p3_q, n3_q;
            assign c3_nxt = (nxt == '0) ? 2'd0 :
                            (c3_q == 2'd2) ? 2'd0 : c3_q + 2'd1;
            // Modulo-3 phase, restarted on every /N wrap.
            always_ff @(posedge bclk) begin
                if (!rst_n) begin
                    c3_q <= 2'd2;
                    p3_q <= 1'b0;
                end else begin
                    c3_q <= c3_nxt;
                    p3_q <= (c3_nxt == 2'd0);
                end
            end
            // Falling-edge copy gives the 1.5-period high phase.
            always_ff @(negedge bclk) begin
                if (!rst_n) n3_q <= 1'b0;
                else        n3_q <= p3_q;
            end
            assign fix_o = p3_q | n3_q;
        end
    endgenerate

    // R2: the count stays below the ratio loaded one cycle earlier.
    p_cnt_bound_r2: assert property (@(posedge bclk) disable iff (!rst_n)
        cnt_q < n_prev);

    // R10: a configuration change zeroes the count on the next edge.
    p_restart_r10: assert property (@(posedge bclk) disable iff (!rst_n)
        chg |=> (cnt_q == '0));

    // R4 and R5: every /N rising edge finds the /2 tap high.
    p_tap_align_r4: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(pos_q) |-> t2_q);
endmodule

// File: rtl/dbx_out_gate.sv
// One crosspoint output: picks a source by code and gates it with an enable
// that is resampled only on the falling edge of the picked source, so a
// pulse is never shortened or started mid-phase. It assumes the reserved slot
// of src_i is tied low.
module dbx_out_gate #(
    parameter int SEL_W   = 3,
    parameter int NUM_SRC = 8
) (
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic               en_i,
    input  logic               rst_n,
    output logic               clk_o
);
    logic pick, en_q;

    assign pick = src_i[sel_i];

    // Enable register, updated only while the source goes low.
    always_ff @(negedge pick) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= en_i;
    end

    assign clk_o = pick & en_q;
endmodule

// File: rtl/dual_bank_clk_xbar.sv
// Top of the output crosspoint: selects each bank's input clock, runs the
// two divider banks (bank 1 with a /3 tap, bank 2 with a /4 tap) and routes
// the seven live sources to NUM_OUT gated outputs. It assumes route_sel packs
// the selector of output 1 in its top bits.
module dual_bank_clk_xbar
    import dbx_pkg::*;
#(
    parameter int NUM_OUT  = 6,
    parameter int DIVN_W   = 7,
    parameter int DIVN_MIN = 4
) (
    input  logic                     vco_clk,
    input  logic                     ref_clk,
    input  logic                     rst_n,
    input  logic [DIVN_W:0]          bank1_cfg,
    input  logic [DIVN_W:0]          bank2_cfg,
    input  logic [NUM_OUT*SEL_W-1:0] route_sel,
    input  logic [NUM_OUT-1:0]       out_en,
    output logic [NUM_OUT-1:0]       clk_out
);
    logic b1_clk, b2_clk;
    logic b1_n, b1_half, b1_fix, b2_n, b2_half, b2_fix;
    logic [NUM_SRC-1:0] src_vec;

    // Bank input clocks: source bit 1 picks the reference.
    assign b1_clk = bank1_cfg[DIVN_W] ? ref_clk : vco_clk;
    assign b2_clk = bank2_cfg[DIVN_W] ? ref_clk : vco_clk;

    dbx_div_bank #(.N_W(DIVN_W), .N_MIN(DIVN_MIN), .FIX_RATIO(3)) u_bank1 (
        .bclk    (b1_clk),
        .rst_n   (rst_n),
        .src_bit (bank1_cfg[DIVN_W]),
        .n_cfg   (bank1_cfg[DIVN_W-1:0]),
        .div_n_o (b1_n),
        .half_o  (b1_half),
        .fix_o   (b1_fix)
    );

    dbx_div_bank #(.N_W(DIVN_W), .N_MIN(DIVN_MIN), .FIX_RATIO(4)) u_bank2 (
        .bclk    (b2_clk),
        .rst_n   (rst_n),
        .src_bit (bank2_cfg[DIVN_W]),
        .n_cfg   (bank2_cfg[DIVN_W-1:0]),
        .div_n_o (b2_n),
        .half_o  (b2_half),
        .fix_o   (b2_fix)
    );

    // Source slots in selector-code order; the reserved slot is tied low.
    always_comb begin
        src_vec              = '0;
        src_vec[SRC_REF]     = ref_clk;
        src_vec[SRC_B1_N]    = b1_n;
        src_vec[SRC_B1_HALF] = b1_half;
        src_vec[SRC_B1_FIX]  = b1_fix;
        src_vec[SRC_B2_N]    = b2_n;
        src_vec[SRC_B2_HALF] = b2_half;
        src_vec[SRC_B2_FIX]  = b2_fix;
    end

    generate
        for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
            localparam int LSB = (NUM_OUT - 1 - k) * SEL_W;

            dbx_out_gate #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_gate (
                .src_i (src_vec),
                .sel_i (route_sel[LSB +: SEL_W]),
                .en_i  (out_en[k]),
                .rst_n (rst_n),
                .clk_o (clk_out[k])
            );

            // R7: a reserved selector keeps the output low.
            p_rsv_low_r7: assert property (@(posedge vco_clk) disable iff (!rst_n)
                (route_sel[LSB +: SEL_W] == SRC_RSVD) |-> !clk_out[k]);
        end
    endgenerate
endmodule

// File: tb/test_dual_bank_clk_xbar.sv
`timescale 1ns/100ps
module test_dual_bank_clk_xbar;
    logic        vco_clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n   = 1'b0;
    logic [7:0]  bank1_cfg, bank2_cfg;
    logic [17:0] route_sel;
    logic [5:0]  out_en;
    logic [5:0]  clk_out;

    int  n_run  = 0;
    int  n_fail = 0;
    real last_rise [6];
    real prev_rise [6];
    real last_fall [6];
    int  rise_cnt  [6];

    // 250 MHz VCO, 100 MHz reference.
    always #2 vco_clk = ~vco_clk;
    always #5 ref_clk = ~ref_clk;

    dual_bank_clk_xbar i_dual_bank_clk_xbar (
        .vco_clk   (vco_clk),
        .ref_clk   (ref_clk),
        .rst_n     (rst_n),
        .bank1_cfg (bank1_cfg),
        .bank2_cfg (bank2_cfg),
        .route_sel (route_sel),
        .out_en    (out_en),
        .clk_out   (clk_out)
    );

    for (genvar k = 0; k < 6; k++) begin : g_mon
        always @(posedge clk_out[k]) begin
            prev_rise[k] = last_rise[k];
            last_rise[k] = $realtime;
            rise_cnt[k]  = rise_cnt[k] + 1;
        end
        always @(negedge clk_out[k]) last_fall[k] = $realtime;
    end

    // Vectors: {bank1_cfg, bank2_cfg, sel CLK1..CLK6}
    localparam logic [33:0] VEC [4] = '{
        {8'h06, 8'h08, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6},
        {8'h8C, 8'h05, 3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd0},
        {8'h07, 8'h90, 3'd1, 3'd4, 3'd5, 3'd6, 3'd1, 3'd0},
        {8'h02, 8'h83, 3'd1, 3'd4, 3'd2, 3'd6, 3'd5, 3'd0}
    };

    task automatic chk_t(input string tag, input real act, input real exp);
        n_run++;
        if (act - exp > 0.05 || exp - act > 0.05) begin
            n_fail++;
            $display("FAIL %s: actual %0.2f expected %0.2f", tag, act, exp);
        end
    endtask

    task automatic chk_b(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic chk_i(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected period and high time from the requirements.
    task automatic expect_of(input logic [2:0] code, input logic [7:0] c1,
                             input logic [7:0] c2, output real per,
                             output real hi, output string req);
        real t1, t2;
        int  n1, n2;
        t1 = c1[7] ? 10.0 : 4.0;
        t2 = c2[7] ? 10.0 : 4.0;
        n1 = (c1[6:0] < 7'd4) ? 4 : int'(c1[6:0]);
        n2 = (c2[6:0] < 7'd4) ? 4 : int'(c2[6:0]);
        per = 0.0; hi = 0.0; req = "R6";
        case (code)
            3'd0: begin per = 10.0;   hi = 5.0;      req = "R6"; end
            3'd1: begin per = n1 * t1; hi = per / 2.0;
                  req = (c1[6:0] < 7'd4) ? "R3" : (c1[7] ? "R1/R2" : "R2"); end
            3'd2: begin per = 2.0 * t1; hi = t1;       req = "R4"; end
            3'd3: begin per = 3.0 * t1; hi = 1.5 * t1; req = "R4"; end
            3'd4: begin per = n2 * t2; hi = per / 2.0;
                  req = (c2[6:0] < 7'd4) ? "R3" : (c2[7] ? "R1/R2" : "R2"); end
            3'd5: begin per = 2.0 * t2; hi = t2;       req = "R5"; end
            3'd6: begin per = 4.0 * t2; hi = 2.0 * t2; req = "R5"; end
            default: ;
        endcase
    endtask

    task automatic chk_align(input int a, input int b, input string tag);
        @(posedge clk_out[a]);
        #0.5;
        chk_t(tag, last_rise[b], last_rise[a]);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog (all requirements): actual not finished, expected finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        real   per, hi, per_m, hi_m;
        string req;
        logic [2:0] code;
        int    c_a, c_b;
        for (int k = 0; k < 6; k++) begin
            last_rise[k] = 0.0; prev_rise[k] = 0.0; last_fall[k] = 0.0; rise_cnt[k] = 0;
        end
        bank1_cfg = 8'h08;
        bank2_cfg = 8'h08;
        route_sel = '0;
        out_en    = 6'h3F;

        // R11: outputs low throughout reset, even with the reference routed.
        repeat (15) @(posedge vco_clk);
        for (int i = 0; i < 4; i++) begin
            #3.5;
            chk_i($sformatf("R11 reset sample %0d", i), int'(clk_out), 0);
        end
        #0.5;
        rst_n = 1'b1;
        #0.5;

        // Table of configurations, each output's period and high time.
        for (int v = 0; v < 4; v++) begin
            {bank1_cfg, bank2_cfg, route_sel} = VEC[v];
            out_en = 6'h3F;
            #1500;
            for (int k = 0; k < 6; k++) begin
                code = route_sel[(5 - k) * 3 +: 3];
                expect_of(code, bank1_cfg, bank2_cfg, per, hi, req);
                per_m = last_rise[k] - prev_rise[k];
                hi_m  = (last_fall[k] > last_rise[k]) ? last_fall[k] - last_rise[k]
                                                      : last_fall[k] - prev_rise[k];
                chk_t($sformatf("%s v%0d CLK%0d period", req, v, k + 1), per_m, per);
                chk_t($sformatf("%s v%0d CLK%0d high", req, v, k + 1), hi_m, hi);
            end
        end

        // R7 reserved code on CLK3, R8 CLK5 disabled.
        bank1_cfg = 8'h08;
        bank2_cfg = 8'h10;
        route_sel = {3'd1, 3'd2, 3'd7, 3'd4, 3'd5, 3'd6};
        out_en    = 6'b101111;
        #1000;
        c_a = rise_cnt[2];
        c_b = rise_cnt[4];
        #500;
        chk_i("R7 reserved CLK3 rises", rise_cnt[2] - c_a, 0);
        chk_b("R7 reserved CLK3 level", clk_out[2], 1'b0);
        chk_i("R8 disabled CLK5 rises", rise_cnt[4] - c_b, 0);
        chk_b("R8 disabled CLK5 level", clk_out[4], 1'b0);

        // R4 and R5 tap alignment.
        out_en = 6'h3F;
        #200;
        chk_align(0, 1, "R4 bank1 /2 aligned N=8");
        chk_align(3, 4, "R5 bank2 /2 aligned N=16");
        chk_align(3, 5, "R5 bank2 /4 aligned N=16");
        bank1_cfg = 8'h06;
        route_sel = {3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
        #1000.5;
        chk_align(0, 2, "R4 bank1 /3 aligned N=6");

        // R10 restart on N change and on source change.
        bank1_cfg = 8'h0C;
        #1000.5;
        chk_align(0, 1, "R10 bank1 /2 aligned after N change");
        chk_align(0, 2, "R10 bank1 /3 aligned after N change");
        #0.5;
        chk_t("R10 bank1 /N period after N change", last_rise[0] - prev_rise[0], 48.0);
        bank2_cfg = 8'h98;
        #1500.5;
        chk_align(3, 5, "R10 bank2 /4 aligned after source change");
        chk_align(3, 4, "R10 bank2 /2 aligned after source change");
        #0.5;
        chk_t("R10 bank2 /N period after source change", last_rise[3] - prev_rise[3], 240.0);

        // R9 enable takes effect only on a falling source edge.
        route_sel = {3'd0, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6};
        out_en    = 6'b111110;
        #100;
        @(posedge ref_clk);
        #2.5;
        out_en[0] = 1'b1;
        #0.5;
        chk_b("R9 enable mid-high, no partial pulse", clk_out[0], 1'b0);
        @(posedge ref_clk);
        #0.5;
        chk_b("R9 enabled output follows source", clk_out[0], 1'b1);
        #1.5;
        out_en[0] = 1'b0;
        #0.5;
        chk_b("R9 disable mid-high, pulse finishes", clk_out[0], 1'b1);
        @(negedge ref_clk);
        #0.5;
        chk_b("R9 low after falling edge", clk_out[0], 1'b0);
        @(posedge ref_clk);
        #0.5;
        chk_b("R8 disabled output stays low", clk_out[0], 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule